// File: doc/BRIEF.md
# Signed Adder-Subtractor with Dual Overflow Detection

This block is a purely combinational N-bit two's-complement arithmetic unit with a single operation select. When the select is low it produces the sum of the two operands; when it is high it produces the first operand minus the second. Both operations run through one ripple chain of full-adder cells. For subtraction the second operand is inverted bit by bit and a one is seeded into the lowest carry input, so no separate subtract path exists.

Beside the N-bit result the block reports the carry leaving the top cell and a signed overflow flag. Overflow is derived twice from independent parts of the logic: once from the sign bits of the operands presented to the chain and of the result, and once from the disagreement between the carry entering and the carry leaving the top cell. Both flags appear at the ports so that a consumer or a checker can compare them. A small control module turns the select into a strobe struct that steers the datapath.

Top module: `addsub_unit`

## Requirements
- R1: With opSub = 0, result equals (opA + opB) modulo 2^WIDTH, operands read as unsigned bit patterns.
- R2: With opSub = 1, result equals (opA - opB) modulo 2^WIDTH.
- R3: With opSub = 0, carryOut equals bit WIDTH of the unsigned sum opA + opB.
- R4: With opSub = 1, carryOut is 1 when opA >= opB as unsigned numbers (no borrow) and 0 otherwise; it is not inverted into a borrow.
- R5: overflow is 1 exactly when the true signed result of the selected operation, with opA and opB read as two's complement, lies outside the range -2^(WIDTH-1) to 2^(WIDTH-1)-1.
- R6: overflowSign, formed from the sign bits of the chain's operands and result, equals overflow, formed from the carries around the top cell, for every input.
- R7: With opSub = 1 and opB = 0, result equals opA, carryOut is 1 and both overflow flags are 0.
- R8: The default WIDTH is 8 and the same logic works unchanged at WIDTH = 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand, two's complement |
| opB | input | WIDTH | Second operand, two's complement |
| opSub | input | 1 | 0 selects addition, 1 selects subtraction |
| result | output | WIDTH | Sum or difference, modulo 2^WIDTH |
| carryOut | output | 1 | Carry out of the top cell (not-borrow when subtracting) |
| overflow | output | 1 | Signed overflow from the carries into and out of the top cell |
| overflowSign | output | 1 | Signed overflow from operand and result sign bits |

## Verification
At four bits every operand pair is applied in both modes, which separates a chain that drops the carry seed or inverts the wrong operand from a correct one, and exposes each sign combination that can or cannot overflow. At eight bits directed corners (largest positive plus one, most negative minus one, zero minus the most negative value, subtracting zero, all-ones plus one) pin down the carry and overflow edges, where a borrow-style carry or a flag taken from the wrong carry pair would show. A long run of pseudo-random eight-bit pairs in both modes compares every output against integer arithmetic and checks that the two overflow flags never disagree.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  // Strobes the control hands to the datapath.
  typedef struct packed {
    logic invertOperand;  // complement operand B before the chain
    logic carrySeed;      // carry into the lowest cell
  } addsub_strobe_t;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } addsub_op_e;

endpackage

// File: rtl/addsub_ctrl.sv
module addsub_ctrl
  import addsub_pkg::*;
(
  input  logic           opSub,
  output addsub_strobe_t strobes
);

  addsub_op_e opKind;

  always_comb begin
    opKind = addsub_op_e'(opSub);
    strobes = '0;
    case (opKind)
      OP_ADD: begin
        strobes.invertOperand = 1'b0;
        strobes.carrySeed     = 1'b0;
      end
      OP_SUB: begin
        strobes.invertOperand = 1'b1;
        strobes.carrySeed     = 1'b1;
      end
      default: strobes = '0;
    endcase
  end

  // Subtract needs both the complement and the +1; add needs neither (R2).
  always_comb begin
    p_strobe_pair_r2: assert (strobes.invertOperand == strobes.carrySeed)
      else $error("strobes disagree");
  end

endmodule

// File: rtl/addsub_fa.sv
module addsub_fa (
  input  logic bitX,
  input  logic bitY,
  input  logic carryIn,
  output logic sumBit,
  output logic carryNext
);

  logic halfSum;

  always_comb begin
    halfSum   = bitX ^ bitY;
    sumBit    = halfSum ^ carryIn;
    carryNext = (bitX & bitY) | (bitX & carryIn) | (bitY & carryIn);
  end

  // Cell arithmetic: two-bit output counts the ones among the inputs (R1).
  always_comb begin
    p_cell_count_r1: assert ({carryNext, sumBit} ==
                             (2'(bitX) + 2'(bitY) + 2'(carryIn)))
      else $error("full adder cell miscounts");
  end

endmodule

// File: rtl/addsub_datapath.sv
module addsub_datapath
  import addsub_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  addsub_strobe_t   strobes,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             overflow,
  output logic             overflowSign
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] operandY;
  logic [WIDTH:0]   carryChain;
  logic [WIDTH-1:0] sumBits;

  always_comb begin
    operandY      = opB ^ {WIDTH{strobes.invertOperand}};
    carryChain[0] = strobes.carrySeed;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    addsub_fa u_fa (
      .bitX     (opA[i]),
      .bitY     (operandY[i]),
      .carryIn  (carryChain[i]),
      .sumBit   (sumBits[i]),
      .carryNext(carryChain[i+1])
    );
  end

  always_comb begin
    result   = sumBits;
    carryOut = carryChain[WIDTH];
    // Carry-based: carry into the top cell differs from carry out of it.
    overflow = carryChain[MSB] ^ carryChain[WIDTH];
    // Sign-based: chain operands agree in sign, result sign departs from it.
    overflowSign = (opA[MSB] == operandY[MSB]) && (sumBits[MSB] != opA[MSB]);
  end

  // The two overflow derivations must match on every input (R6).
  always_comb begin
    p_flags_agree_r6: assert (overflow == overflowSign)
      else $error("overflow derivations disagree");
  end

endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             opSub,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             overflow,
  output logic             overflowSign
);

  addsub_strobe_t strobes;

  addsub_ctrl u_ctrl (
    .opSub  (opSub),
    .strobes(strobes)
  );

  addsub_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA         (opA),
    .opB         (opB),
    .strobes     (strobes),
    .result      (result),
    .carryOut    (carryOut),
    .overflow    (overflow),
    .overflowSign(overflowSign)
  );

  always_comb begin
    if (!opSub) begin
      p_add_value_r1: assert (result == WIDTH'(opA + opB))
        else $error("sum wrong");
      p_add_carry_r3: assert (carryOut == (({1'b0, opA} + {1'b0, opB}) >> WIDTH))
        else $error("add carry wrong");
    end else begin
      p_sub_value_r2: assert (result == WIDTH'(opA - opB))
        else $error("difference wrong");
      p_sub_carry_r4: assert (carryOut == (opA >= opB))
        else $error("subtract carry is not no-borrow");
    end
  end

endmodule

// File: tb/sim_addsub_unit.sv
module sim_addsub_unit;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [7:0] a8, b8;
  logic       s8;
  logic [7:0] r8;
  logic       c8, v8, w8;

  logic [3:0] a4, b4;
  logic       s4;
  logic [3:0] r4;
  logic       c4, v4, w4;

  addsub_unit u0 (
    .opA(a8), .opB(b8), .opSub(s8),
    .result(r8), .carryOut(c8), .overflow(v8), .overflowSign(w8)
  );

  addsub_unit #(.WIDTH(4)) u1 (
    .opA(a4), .opB(b4), .opSub(s4),
    .result(r4), .carryOut(c4), .overflow(v4), .overflowSign(w4)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference from integer arithmetic, then compare all four outputs.
  task automatic apply(input int w, input int ua, input int ub, input bit sub);
    int modv, half, sa, sb, trueVal, expRes, expCarry, expOvf;
    int actRes, actC, actV, actW;
    modv = 1 << w;
    half = 1 << (w - 1);
    sa = (ua >= half) ? ua - modv : ua;
    sb = (ub >= half) ? ub - modv : ub;
    if (sub) begin
      trueVal  = sa - sb;
      expRes   = (ua - ub + modv) % modv;
      expCarry = (ua >= ub) ? 1 : 0;
    end else begin
      trueVal  = sa + sb;
      expRes   = (ua + ub) % modv;
      expCarry = (ua + ub) / modv;
    end
    expOvf = (trueVal < -half || trueVal > half - 1) ? 1 : 0;
    @(posedge clk);
    if (w == 4) begin a4 = 4'(ua); b4 = 4'(ub); s4 = sub; end
    else        begin a8 = 8'(ua); b8 = 8'(ub); s8 = sub; end
    @(negedge clk);
    if (w == 4) begin actRes = int'(r4); actC = int'(c4); actV = int'(v4); actW = int'(w4); end
    else        begin actRes = int'(r8); actC = int'(c8); actV = int'(v8); actW = int'(w8); end
    if (sub) begin
      chk("R2", "difference", actRes, expRes);
      chk("R4", "no-borrow carry", actC, expCarry);
    end else begin
      chk("R1", "sum", actRes, expRes);
      chk("R3", "carry", actC, expCarry);
    end
    chk("R5", "overflow", actV, expOvf);
    chk("R6", "sign-based overflow agrees", actW, actV);
  endtask

  task automatic t_idle;
    @(posedge clk);
    a8 = '0; b8 = '0; s8 = 1'b0; a4 = '0; b4 = '0; s4 = 1'b0;
    @(negedge clk);
    chk("R1", "idle result", int'(r8), 0);
    chk("R3", "idle carry", int'(c8), 0);
    chk("R5", "idle overflow", int'(v8), 0);
    chk("R8", "idle result narrow", int'(r4), 0);
  endtask

  task automatic t_exhaustive4;
    for (int m = 0; m < 2; m++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          apply(4, x, y, m[0]);  // R8 width 4
  endtask

  task automatic t_corners8;
    apply(8, 127, 1, 1'b0);    // positive overflow, R5
    apply(8, 128, 1, 1'b1);    // -128 - 1 overflows
    apply(8, 0, 128, 1'b1);    // 0 - (-128) overflows, borrow
    apply(8, 255, 1, 1'b0);    // carry out, no overflow
    apply(8, 128, 128, 1'b0);  // -128 + -128
    apply(8, 200, 200, 1'b1);  // equal operands, no borrow
    apply(8, 3, 4, 1'b1);      // borrow
  endtask

  task automatic t_sub_zero;
    for (int x = 0; x < 256; x += 37) begin
      @(posedge clk);
      a8 = 8'(x); b8 = '0; s8 = 1'b1;
      @(negedge clk);
      chk("R7", "A-0 result", int'(r8), x);
      chk("R7", "A-0 carry", int'(c8), 1);
      chk("R7", "A-0 overflow", int'(v8), 0);
      chk("R7", "A-0 sign overflow", int'(w8), 0);
    end
  endtask

  task automatic t_random8;
    for (int k = 0; k < 3000; k++)
      apply(8, int'($urandom_range(255)), int'($urandom_range(255)), k[0]);
  endtask

  initial begin
    a8 = '0; b8 = '0; s8 = 1'b0; a4 = '0; b4 = '0; s4 = 1'b0;
    t_idle;
    t_exhaustive4;
    t_corners8;
    t_sub_zero;
    t_random8;
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule